// File: doc/BRIEF.md
# Two-Stage Instruction Cache with Virtual Index and Physical Tag

This block is a 2-way set-associative instruction cache for a fetch unit. It is split into two pipeline stages. In the first stage the set index, taken from the untranslated low bits of the virtual fetch address, reads the data, tag and replacement memories. In the second stage the physical tag arrives from an external translation unit in the same cycle. It is compared against both stored tags, and the fetched word is selected from the hitting way. Each of the three memories is a single-port synchronous RAM that can either read or write in a given cycle.

The cache never holds the fetch pipeline. Every lookup gets a response exactly one cycle later, flagged as a hit or a miss, and a new lookup can be presented every cycle. On a miss the fetch unit replays the request after the missing line has been supplied through a separate fill port. A fill writes a whole line into the least-recently-used way of its set. While the fill occupies the memory ports it takes priority, and any lookup that collides with it is answered as a miss. After reset the cache spends one cycle per set clearing its tags before it can hold any line.

Top module: `instrCache`

## Requirements
- R1: After reset is released the cache clears itself for SETS (64) cycles. During that time every lookup is answered as a miss and every fill is discarded, and afterwards no set holds a valid line.
- R2: A lookup presented with lookupValid in cycle t gets respValid in cycle t+1 and in no other cycle. Lookups may be presented in consecutive cycles without any stall.
- R3: The set is lookupVaddr[11:6]. The physical tag on lookupPtag in the response cycle is compared with both ways of that set. On a match to a valid way respHit is 1 and respWord is word lookupVaddr[5:2] of that line, where word k is bits [32k+31:32k] of the line.
- R4: When neither valid way of the set matches the physical tag, respHit is 0.
- R5: An accepted fill for set fillSet writes fillLine and fillPtag into the way named by that set's replacement bit and marks it valid. It then sets the replacement bit to the other way. After the self-clear every replacement bit names way 0.
- R6: A lookup hit sets the replacement bit of its set to the way that did not hit.
- R7: A lookup presented in the same cycle as an accepted fill is answered as a miss.
- R8: A lookup presented in the cycle directly after an accepted fill is answered as a miss.
- R9: A fill presented in the cycle directly after an accepted fill is discarded.
- R10: A lookup hit whose response cycle coincides with the presentation of an accepted fill leaves the replacement bit unchanged, so that fill chooses its way from the earlier replacement bit.
- R11: Virtual address bits above bit 11 play no part in the lookup: two addresses that differ only there, with the same physical tag, reach the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookupValid | input | 1 | Fetch lookup request in the lookup stage |
| lookupVaddr | input | VA_W (32) | Virtual fetch address |
| lookupPtag | input | PTAG_W (20) | Physical tag of the request, presented in the response cycle |
| fillValid | input | 1 | Line fill request |
| fillSet | input | log2(SETS) (6) | Set written by the fill |
| fillPtag | input | PTAG_W (20) | Physical tag stored with the filled line |
| fillLine | input | LINE_BYTES*8 (512) | Line contents, word k at bits [32k+31:32k] |
| respValid | output | 1 | Response for the lookup of the previous cycle |
| respHit | output | 1 | 1 on hit, 0 on miss (replay required) |
| respWord | output | FETCH_W (32) | Fetched word, meaningful when respHit is 1 |

## Verification
The hardest situation to reach is the contention on the single replacement-memory port. In that case a lookup hit wants to record its way in exactly the cycle a new fill wants to read the victim way of the same set. The bench fills both ways of one set, then issues a lookup to way 0 and presents a fill to that set one cycle later. This places the hit's response cycle on the fill's lookup cycle. Which line survives then shows at the ports whether the hit update was dropped. The other collisions between fills and lookups are timed in the same way: same-cycle, next-cycle and back-to-back fills, plus lookups and fills during the post-reset self-clear.

// File: rtl/icPkg.sv
package icPkg;

  // number of ways is structural: a single replacement bit per set
  localparam int WAYS = 2;

  // which index drives a memory port this cycle
  typedef enum logic [1:0] {
    SRC_TL   = 2'd0,
    SRC_TV   = 2'd1,
    SRC_INIT = 2'd2
  } addrSrc_e;

  // value written into the replacement memory
  typedef enum logic [1:0] {
    LRU_ZERO = 2'd0,
    LRU_FILL = 2'd1,
    LRU_HIT  = 2'd2
  } lruSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     tlFill;   // fill accepted in the lookup stage
    logic     dataWe;   // write data memory (fill way lane)
    logic     tagWe;    // write tag memory
    logic     lruWe;    // write replacement memory
    addrSrc_e dtAddr;   // index source for data and tag memories
    addrSrc_e lruAddr;  // index source for replacement memory
    lruSrc_e  lruSrc;   // replacement write value
  } icStrobe_t;

endpackage

// File: rtl/icSram.sv
// Single-port synchronous RAM: each cycle either writes the enabled lanes
// or reads the whole word into a registered output.
module icSram #(
  parameter int LANE_W = 8,
  parameter int LANES  = 1,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic [LANES-1:0] laneWe,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (|laneWe) begin
      for (int l = 0; l < LANES; l++) begin
        if (laneWe[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end else begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/icCtrl.sv
// Pipeline control: stage valid bits, port arbitration, self-clear sweep.
module icCtrl
  import icPkg::*;
#(
  parameter int SETS   = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookupValid,
  input  logic             fillValid,
  input  logic             hitAny,
  output icStrobe_t        strobe,
  output logic             respValid,
  output logic             respHit,
  output logic             tvFill,
  output logic             initActive,
  output logic [IDX_W-1:0] initIdx
);

  logic tvLookup;
  logic tvConflict;
  logic fillAcc;
  logic hitOk;

  // a fill is taken unless clearing or the previous fill is still writing
  assign fillAcc = fillValid & ~initActive & ~tvFill;
  // a lookup whose memories were not read for it cannot hit
  assign hitOk   = tvLookup & ~tvConflict & hitAny;

  always_ff @(posedge clk) begin
    if (rst) begin
      initActive <= 1'b1;
      initIdx    <= '0;
      tvFill     <= 1'b0;
      tvLookup   <= 1'b0;
      tvConflict <= 1'b0;
    end else begin
      tvFill     <= fillAcc;
      tvLookup   <= lookupValid;
      tvConflict <= fillAcc | tvFill | initActive;
      if (initActive) begin
        initIdx <= initIdx + IDX_W'(1);
        if (initIdx == IDX_W'(SETS - 1)) initActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.tlFill  = fillAcc;
    strobe.dataWe  = 1'b0;
    strobe.tagWe   = 1'b0;
    strobe.lruWe   = 1'b0;
    strobe.dtAddr  = SRC_TL;
    strobe.lruAddr = SRC_TL;
    strobe.lruSrc  = LRU_HIT;
    if (initActive) begin
      strobe.tagWe   = 1'b1;
      strobe.lruWe   = 1'b1;
      strobe.dtAddr  = SRC_INIT;
      strobe.lruAddr = SRC_INIT;
      strobe.lruSrc  = LRU_ZERO;
    end else if (tvFill) begin
      strobe.dataWe  = 1'b1;
      strobe.tagWe   = 1'b1;
      strobe.lruWe   = 1'b1;
      strobe.dtAddr  = SRC_TV;
      strobe.lruAddr = SRC_TV;
      strobe.lruSrc  = LRU_FILL;
    end else if (hitOk && !fillAcc) begin
      // hit update yields the replacement port to a fill reading its victim
      strobe.lruWe   = 1'b1;
      strobe.lruAddr = SRC_TV;
    end
  end

  assign respValid = tvLookup;
  assign respHit   = hitOk;

endmodule

// File: rtl/icDatapath.sv
// Memories, stage registers, tag compare and word selection.
module icDatapath
  import icPkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PTAG_W     = 20,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORDS     = LINE_W / FETCH_W,
  localparam int SEL_W     = $clog2(WORDS),
  localparam int BSEL_W    = $clog2(FETCH_W / 8),
  localparam int TAGE_W    = PTAG_W + 1
) (
  input  logic              clk,
  input  icStrobe_t         strobe,
  input  logic [VA_W-1:0]   lookupVaddr,
  input  logic [PTAG_W-1:0] lookupPtag,
  input  logic [IDX_W-1:0]  fillSet,
  input  logic [PTAG_W-1:0] fillPtag,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [IDX_W-1:0]  initIdx,
  output logic              hitAny,
  output logic [FETCH_W-1:0] respWord
);

  // lookup-stage index
  logic [IDX_W-1:0]  tlLookIdx;
  logic [IDX_W-1:0]  tlIdx;
  // verify-stage registers
  logic [IDX_W-1:0]  tvIdx;
  logic [SEL_W-1:0]  tvWordSel;
  logic [PTAG_W-1:0] tvFillTag;
  logic [LINE_W-1:0] tvFillLine;

  // memory ports
  logic [IDX_W-1:0]         dtAddr;
  logic [IDX_W-1:0]         lruAddr;
  logic [WAYS*LINE_W-1:0]   dataRd;
  logic [WAYS*TAGE_W-1:0]   tagRd;
  logic [WAYS*TAGE_W-1:0]   tagWd;
  logic [WAYS-1:0]          dataLaneWe;
  logic [WAYS-1:0]          tagLaneWe;
  logic [0:0]               lruRd;
  logic [0:0]               lruWd;

  logic [WAYS-1:0]   wayHit;
  logic [WAYS-1:0]   wayFillSel;
  logic [LINE_W-1:0] wayLine [WAYS];
  logic              hitWay;
  logic              fillWay;
  logic [LINE_W-1:0] hitLine;

  // only page-offset bits index the cache; the rest are translated outside
  logic unusedVaBits;
  assign unusedVaBits = ^{lookupVaddr[VA_W-1:OFF_W+IDX_W], lookupVaddr[BSEL_W-1:0]};

  assign tlLookIdx = lookupVaddr[OFF_W +: IDX_W];
  assign tlIdx     = strobe.tlFill ? fillSet : tlLookIdx;

  always_ff @(posedge clk) begin
    tvIdx     <= tlIdx;
    tvWordSel <= lookupVaddr[BSEL_W +: SEL_W];
    if (strobe.tlFill) begin
      tvFillTag  <= fillPtag;
      tvFillLine <= fillLine;
    end
  end

  always_comb begin
    case (strobe.dtAddr)
      SRC_INIT: dtAddr = initIdx;
      SRC_TV:   dtAddr = tvIdx;
      default:  dtAddr = tlIdx;
    endcase
    case (strobe.lruAddr)
      SRC_INIT: lruAddr = initIdx;
      SRC_TV:   lruAddr = tvIdx;
      default:  lruAddr = tlIdx;
    endcase
  end

  // victim read during the fill's lookup stage, used in its verify stage
  assign fillWay = lruRd[0];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : gWay
      assign wayHit[w]     = tagRd[w*TAGE_W + PTAG_W] &&
                             (tagRd[w*TAGE_W +: PTAG_W] == lookupPtag);
      assign wayFillSel[w] = (fillWay == 1'(w));
      assign wayLine[w]    = dataRd[w*LINE_W +: LINE_W];
      assign tagWd[w*TAGE_W +: TAGE_W] = (strobe.dtAddr == SRC_INIT) ?
                                         '0 : {1'b1, tvFillTag};
    end
  endgenerate

  assign hitAny  = |wayHit;
  assign hitWay  = wayHit[1] & ~wayHit[0];
  assign hitLine = wayLine[hitWay];
  assign respWord = hitLine[tvWordSel*FETCH_W +: FETCH_W];

  assign dataLaneWe = strobe.dataWe ? wayFillSel : '0;
  assign tagLaneWe  = !strobe.tagWe ? '0 :
                      (strobe.dtAddr == SRC_INIT) ? '1 : wayFillSel;

  always_comb begin
    case (strobe.lruSrc)
      LRU_FILL: lruWd = ~fillWay;
      LRU_HIT:  lruWd = ~hitWay;
      default:  lruWd = 1'b0;
    endcase
  end

  icSram #(.LANE_W(LINE_W), .LANES(WAYS), .DEPTH(SETS)) u_dataMem (
    .clk   (clk),
    .laneWe(dataLaneWe),
    .addr  (dtAddr),
    .wdata ({WAYS{tvFillLine}}),
    .rdata (dataRd)
  );

  icSram #(.LANE_W(TAGE_W), .LANES(WAYS), .DEPTH(SETS)) u_tagMem (
    .clk   (clk),
    .laneWe(tagLaneWe),
    .addr  (dtAddr),
    .wdata (tagWd),
    .rdata (tagRd)
  );

  icSram #(.LANE_W(1), .LANES(1), .DEPTH(SETS)) u_lruMem (
    .clk   (clk),
    .laneWe(strobe.lruWe),
    .addr  (lruAddr),
    .wdata (lruWd),
    .rdata (lruRd)
  );

endmodule

// File: rtl/instrCache.sv
// Two-stage instruction cache: virtual index, physical tag, replay on miss.
module instrCache
  import icPkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PTAG_W     = 20,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 32,
  localparam int IDX_W     = $clog2(SETS),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lookupValid,
  input  logic [VA_W-1:0]    lookupVaddr,
  input  logic [PTAG_W-1:0]  lookupPtag,
  input  logic               fillValid,
  input  logic [IDX_W-1:0]   fillSet,
  input  logic [PTAG_W-1:0]  fillPtag,
  input  logic [LINE_W-1:0]  fillLine,
  output logic               respValid,
  output logic               respHit,
  output logic [FETCH_W-1:0] respWord
);

  icStrobe_t        strobe;
  logic             hitAny;
  logic             tvFill;
  logic             initActive;
  logic [IDX_W-1:0] initIdx;

  icCtrl #(.SETS(SETS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .lookupValid(lookupValid),
    .fillValid  (fillValid),
    .hitAny     (hitAny),
    .strobe     (strobe),
    .respValid  (respValid),
    .respHit    (respHit),
    .tvFill     (tvFill),
    .initActive (initActive),
    .initIdx    (initIdx)
  );

  icDatapath #(
    .VA_W(VA_W), .PTAG_W(PTAG_W), .SETS(SETS),
    .LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W)
  ) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .lookupVaddr(lookupVaddr),
    .lookupPtag (lookupPtag),
    .fillSet    (fillSet),
    .fillPtag   (fillPtag),
    .fillLine   (fillLine),
    .initIdx    (initIdx),
    .hitAny     (hitAny),
    .respWord   (respWord)
  );

endmodule

// File: rtl/instrCacheChecker.sv
module instrCacheChecker (
  input logic clk,
  input logic rst,
  input logic lookupValid,
  input logic fillValid,
  input logic respValid,
  input logic respHit,
  input logic tvFill,
  input logic initActive
);

  AST_RESP_ONE_LATER: assert property (@(posedge clk) disable iff (rst)
    respValid == $past(lookupValid)); // R2

  AST_HIT_HAS_RESP: assert property (@(posedge clk) disable iff (rst)
    respHit |-> respValid); // R3

  AST_CLEAR_MISSES: assert property (@(posedge clk) disable iff (rst)
    $past(initActive) |-> !respHit); // R1

  AST_SAME_CYCLE_FILL_MISS: assert property (@(posedge clk) disable iff (rst)
    $past(lookupValid && fillValid && !initActive && !tvFill) |-> !respHit); // R7

  AST_FILL_WRITE_MISS: assert property (@(posedge clk) disable iff (rst)
    $past(tvFill) |-> !respHit); // R8

  AST_FILL_GAP: assert property (@(posedge clk) disable iff (rst)
    (fillValid && tvFill) |=> !tvFill); // R9

endmodule

bind instrCache instrCacheChecker u_chk (
  .clk        (clk),
  .rst        (rst),
  .lookupValid(lookupValid),
  .fillValid  (fillValid),
  .respValid  (respValid),
  .respHit    (respHit),
  .tvFill     (tvFill),
  .initActive (initActive)
);

// File: tb/instrCache_tb.sv
`timescale 1ns/1ps
module instrCache_tb;

  localparam int SETS   = 64;
  localparam int LINE_W = 512;
  localparam int NVEC   = 19;

  // A..E physical tags
  localparam logic [19:0] TA = 20'h00011;
  localparam logic [19:0] TB = 20'h00022;
  localparam logic [19:0] TC = 20'h00033;
  localparam logic [19:0] TD = 20'h00044;
  localparam logic [19:0] TE = 20'h00055;

  // {isFill, expHit, ptag[19:0], vaddr[31:0]}
  localparam logic [53:0] VEC [NVEC] = '{
    {1'b0, 1'b0, TA, 32'h0000_0140},  // empty set misses (R4)
    {1'b1, 1'b0, TA, 32'h0000_0140},  // fill -> way0 (R5)
    {1'b0, 1'b1, TA, 32'h0000_014C},  // hit word 3 (R3)
    {1'b1, 1'b0, TB, 32'h0000_0140},  // fill -> way1
    {1'b0, 1'b1, TB, 32'h0000_0144},
    {1'b0, 1'b1, TA, 32'h0000_0150},  // hit way0 -> replace way1 next (R6)
    {1'b1, 1'b0, TC, 32'h0000_0140},  // evicts B
    {1'b0, 1'b0, TB, 32'h0000_0140},
    {1'b0, 1'b1, TA, 32'h0000_0154},
    {1'b0, 1'b1, TC, 32'h0000_0158},  // hit way1 -> replace way0 next
    {1'b1, 1'b0, TB, 32'h0000_0140},  // evicts A
    {1'b0, 1'b0, TA, 32'h0000_0140},
    {1'b0, 1'b1, TC, 32'h0000_015C},
    {1'b0, 1'b1, TB, 32'h0000_017C},  // last word
    {1'b0, 1'b0, TC, 32'h0000_0180},  // other set
    {1'b0, 1'b1, TC, 32'hABC0_0148},  // upper virtual bits ignored (R11)
    {1'b1, 1'b0, TA, 32'h0000_0FC0},  // last set
    {1'b0, 1'b1, TA, 32'h0000_0FC0},
    {1'b0, 1'b0, TA, 32'h0000_0000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lookupValid = 1'b0;
  logic [31:0]       lookupVaddr = '0;
  logic [19:0]       lookupPtag  = '0;
  logic              fillValid   = 1'b0;
  logic [5:0]        fillSet     = '0;
  logic [19:0]       fillPtag    = '0;
  logic [LINE_W-1:0] fillLine    = '0;
  logic              respValid;
  logic              respHit;
  logic [31:0]       respWord;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  instrCache u_dut (
    .clk(clk), .rst(rst),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr), .lookupPtag(lookupPtag),
    .fillValid(fillValid), .fillSet(fillSet), .fillPtag(fillPtag), .fillLine(fillLine),
    .respValid(respValid), .respHit(respHit), .respWord(respWord)
  );

  function automatic logic [31:0] mkWord(logic [19:0] pt, logic [5:0] set, logic [3:0] w);
    return {pt[15:0], 2'b10, set, 4'h0, w};
  endfunction

  function automatic logic [LINE_W-1:0] mkLine(logic [19:0] pt, logic [5:0] set);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = mkWord(pt, set, 4'(k));
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // sample the response of a lookup presented one cycle earlier
  task automatic checkResp(input logic [31:0] va, input logic [19:0] pt,
                           input bit expHit, input string req);
    chk(respValid === 1'b1, req, "respValid", 64'(respValid), 64'd1);
    chk(respHit === expHit, req, "respHit", 64'(respHit), 64'(expHit));
    if (expHit)
      chk(respWord === mkWord(pt, va[11:6], va[5:2]), req, "respWord",
          64'(respWord), 64'(mkWord(pt, va[11:6], va[5:2])));
  endtask

  task automatic doLookup(input logic [31:0] va, input logic [19:0] pt,
                          input bit expHit, input string req);
    lookupValid = 1'b1;
    lookupVaddr = va;
    @(negedge clk);
    lookupValid = 1'b0;
    lookupPtag  = pt;
    #1;
    checkResp(va, pt, expHit, req);
    @(negedge clk);
  endtask

  task automatic driveFill(input logic [5:0] set, input logic [19:0] pt);
    fillValid = 1'b1;
    fillSet   = set;
    fillPtag  = pt;
    fillLine  = mkLine(pt, set);
  endtask

  task automatic doFill(input logic [5:0] set, input logic [19:0] pt);
    driveFill(set, pt);
    @(negedge clk);
    fillValid = 1'b0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state (R1)
    repeat (3) @(negedge clk);
    #1;
    chk(respValid === 1'b0, "R1", "respValid in reset", 64'(respValid), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // lookup and fill during self-clear (R1, R2)
    doLookup(32'h0000_0240, TD, 1'b0, "R1 lookup during clear");
    driveFill(6'd9, TD);
    @(negedge clk);
    fillValid = 1'b0;
    repeat (SETS + 4) @(negedge clk);
    doLookup(32'h0000_0240, TD, 1'b0, "R1 fill during clear dropped");

    // table walk: hits, misses, replacement order
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][53]) doFill(VEC[i][11:6], VEC[i][51:32]);
      else doLookup(VEC[i][31:0], VEC[i][51:32], VEC[i][52],
                    $sformatf("R3 R4 R5 R6 R11 vector %0d", i));
    end

    // back-to-back lookups every cycle (R2); set 5 holds B (way0), C (way1)
    lookupValid = 1'b1; lookupVaddr = 32'h0000_0148;
    @(negedge clk);
    lookupVaddr = 32'h0000_015C; lookupPtag = TC;
    #1 checkResp(32'h0000_0148, TC, 1'b1, "R2 stream 1");
    @(negedge clk);
    lookupVaddr = 32'h0000_0140; lookupPtag = TB;
    #1 checkResp(32'h0000_015C, TB, 1'b1, "R2 stream 2");
    @(negedge clk);
    lookupValid = 1'b0; lookupPtag = TA;
    #1 checkResp(32'h0000_0140, TA, 1'b0, "R2 stream 3");
    @(negedge clk);
    #1 chk(respValid === 1'b0, "R2", "respValid idle", 64'(respValid), 64'd0);
    @(negedge clk);

    // R7: lookup in the same cycle as an accepted fill
    lookupValid = 1'b1; lookupVaddr = 32'h0000_0140;
    driveFill(6'd10, TD);
    @(negedge clk);
    lookupValid = 1'b0; fillValid = 1'b0; lookupPtag = TC;
    #1 checkResp(32'h0000_0140, TC, 1'b0, "R7 same-cycle fill");
    @(negedge clk);
    doLookup(32'h0000_0140, TC, 1'b1, "R7 replay hits");
    doLookup(32'h0000_0284, TD, 1'b1, "R7 fill completed");

    // R8: lookup in the cycle after an accepted fill
    driveFill(6'd11, TD);
    @(negedge clk);
    fillValid = 1'b0;
    lookupValid = 1'b1; lookupVaddr = 32'h0000_0140;
    @(negedge clk);
    lookupValid = 1'b0; lookupPtag = TC;
    #1 checkResp(32'h0000_0140, TC, 1'b0, "R8 lookup during fill write");
    @(negedge clk);
    doLookup(32'h0000_02C0, TD, 1'b1, "R8 fill completed");

    // R9: back-to-back fills, second dropped
    driveFill(6'd12, TD);
    @(negedge clk);
    driveFill(6'd12, TE);
    @(negedge clk);
    fillValid = 1'b0;
    @(negedge clk);
    doLookup(32'h0000_0300, TE, 1'b0, "R9 second fill dropped");
    doLookup(32'h0000_0300, TD, 1'b1, "R9 first fill kept");

    // R10: hit update yields to a fill reading the victim of set 20
    doFill(6'd20, TA);                // way0, next victim way1
    doFill(6'd20, TB);                // way1, next victim way0
    lookupValid = 1'b1; lookupVaddr = 32'h0000_0508;
    @(negedge clk);
    lookupValid = 1'b0; lookupPtag = TA;
    driveFill(6'd20, TC);
    #1 checkResp(32'h0000_0508, TA, 1'b1, "R10 colliding hit reported");
    @(negedge clk);
    fillValid = 1'b0;
    @(negedge clk);
    doLookup(32'h0000_0500, TA, 1'b0, "R10 hit update dropped, A evicted");
    doLookup(32'h0000_0504, TB, 1'b1, "R10 B kept");
    doLookup(32'h0000_053C, TC, 1'b1, "R10 C filled");

    // R1: reset in mid-run clears all lines
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (SETS + 4) @(negedge clk);
    doLookup(32'h0000_0140, TC, 1'b0, "R1 lines cleared after reset");
    doLookup(32'h0000_0500, TB, 1'b0, "R1 lines cleared after reset");
    // after clear the victim is way0 again (R5)
    doFill(6'd5, TA);
    doFill(6'd5, TB);
    doLookup(32'h0000_0140, TA, 1'b1, "R5 both ways after clear");
    doLookup(32'h0000_0140, TB, 1'b1, "R5 both ways after clear");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule